// File: doc/BRIEF.md
# DMA Control and Interrupt Register Block

This block is the register front end of a seven-channel DMA controller. A 32-bit register bus with a 7-bit word address reaches three storage words per channel: a memory base address, a block control word and a channel control word. It also reaches two global words. The priority word holds a 3-bit priority and an enable bit for each channel and feeds the arbiter. The interrupt word holds interrupt enables, a force bit, per-channel completion flags and a derived master flag.

The transfer engine reports the end of a channel's transfer with a one-cycle pulse on `done_i`. The block records it as a flag when that channel's interrupt enable is set. It raises `irq_o` for one cycle each time the master flag goes from clear to set. Reads are combinational from `addr_i`. Writes happen on the rising clock edge while `wr_i` is high.

Top module: `dma_reg_front`

## Requirements
- R1: After reset the priority word reads 0x07654321. Every other register reads zero, all `chan_en_o` bits are 0, `chan_prio_o` carries 1..7 for channels 0..6, and `irq_o` is low.
- R2: Address bits 6:4 pick a channel slot (0..NUM_CH-1). Within the slot, bits 3:0 equal to 0x0, 0x4 and 0x8 select base address, block control and channel control. Block control and channel control store all 32 bits. The base address keeps only bits 23:0, and bits 31:24 read as zero.
- R3: A read of any address that selects no register returns 0xFFFFFFFF. Examples are offset 0xC of a slot, 0x78 and 0x7C. A write to such an address changes nothing.
- R4: Address 0x70 is a fully writable priority word. For channel c, bit 4c+3 drives `chan_en_o[c]` and bits 4c+2:4c drive `chan_prio_o[3c+2:3c]`.
- R5: A write to address 0x74 replaces only the bits under mask 0x00FF803F. Bit 15 is force, bits 22:16 are the channel interrupt enables, bit 23 is the master enable, and bits 5:0 are plain storage. Bits 14:6 always read zero.
- R6: Writing 1 to bit 24+c of address 0x74 clears the flag of channel c. Writing 0 leaves it unchanged.
- R7: A `done_i[c]` pulse sets flag bit 24+c only if enable bit 16+c is set at that edge. If a completion and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Bit 31 of address 0x74 reads 1 when force is set, or when the master enable is set and some channel has both its enable and its flag set. Writes to bit 31 have no effect.
- R9: `irq_o` is high for exactly the first cycle in which the master flag reads 1 after having read 0. It stays low while the flag stays set.
- R10: `base_o`, `blk_o` and `ctl_o` present the stored per-channel words, packed channel 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | 7 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| done_i | input | NUM_CH | Per-channel completion pulse from the transfer engine |
| rdata_o | output | 32 | Combinational read data for addr_i |
| base_o | output | NUM_CH*24 | Per-channel base addresses |
| blk_o | output | NUM_CH*32 | Per-channel block control words |
| ctl_o | output | NUM_CH*32 | Per-channel channel control words |
| chan_en_o | output | NUM_CH | Per-channel enable from the priority word |
| chan_prio_o | output | NUM_CH*3 | Per-channel priority from the priority word |
| irq_o | output | 1 | One-cycle pulse on master flag rise |

## Verification
The bench builds the block with the default NUM_CH of 7. At that setting the slot field covers every slot, and slot 7 overlaps the two global words at 0x70 and 0x74. Both the global decode and the undecoded holes at 0x78 and 0x7C can therefore be reached through the normal address path. All seven enable and flag bits of the interrupt word are live at this setting. This lets the bench walk the full write mask and the combinations of clear and completion in the same cycle against its reference model.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 7;
  localparam int unsigned SLOT_W    = 3;
  localparam int unsigned BASE_W    = 24;
  localparam int unsigned MAX_CH    = 7;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned FLAG_LSB  = 24;
  localparam int unsigned FORCE_BIT = 15;
  localparam int unsigned MEN_BIT   = 23;
  localparam int unsigned MFLAG_BIT = 31;

  localparam logic [DW-1:0] PRIO_RST  = 32'h0765_4321;
  localparam logic [DW-1:0] IRQ_WMASK = 32'h00FF_803F;

  localparam logic [3:0]    OFS_BASE  = 4'h0;
  localparam logic [3:0]    OFS_BLK   = 4'h4;
  localparam logic [3:0]    OFS_CTL   = 4'h8;
  localparam logic [AW-1:0] ADDR_PRIO = 7'h70;
  localparam logic [AW-1:0] ADDR_IRQ  = 7'h74;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_BLK  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } chan_sel_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  chan_sel_e         sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic [DW-1:0]     blk_o,
  output logic [DW-1:0]     ctl_o,
  output logic [DW-1:0]     rdata_o
);
  logic [BASE_W-1:0] base_q;
  logic [DW-1:0]     blk_q, ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      blk_q  <= '0;
      ctl_q  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_BASE: base_q <= wdata_i[BASE_W-1:0];
        SEL_BLK:  blk_q  <= wdata_i;
        SEL_CTL:  ctl_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_BASE: rdata_o = {{(DW-BASE_W){1'b0}}, base_q};
      SEL_BLK:  rdata_o = blk_q;
      SEL_CTL:  rdata_o = ctl_q;
      default:  rdata_o = '1;
    endcase
  end

  assign base_o = base_q;
  assign blk_o  = blk_q;
  assign ctl_o  = ctl_q;

  // R2: storage moves only on a write
  p_chan_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({base_q, blk_q, ctl_q}));
endmodule

// File: rtl/dma_prio_reg.sv
module dma_prio_reg
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       q_o,
  output logic [NUM_CH-1:0]   en_o,
  output logic [NUM_CH*3-1:0] prio_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= PRIO_RST;
    else if (we_i) q <= wdata_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_nib
    assign en_o[c]         = q[4*c+3];
    assign prio_o[3*c +: 3] = q[4*c +: 3];
  end

  assign q_o = q;

  // R4: priority word only changes on its own write
  p_prio_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [DW-1:0]     ctl_q;
  logic [NUM_CH-1:0] flag_q, flag_d, en_w, clr_w, set_w;
  logic              force_w, men_w, mflag, mflag_q;

  assign en_w    = ctl_q[EN_LSB +: NUM_CH];
  assign force_w = ctl_q[FORCE_BIT];
  assign men_w   = ctl_q[MEN_BIT];

  // completion wins over a same-cycle clear
  assign clr_w  = we_i ? wdata_i[FLAG_LSB +: NUM_CH] : '0;
  assign set_w  = done_i & en_w;
  assign flag_d = (flag_q & ~clr_w) | set_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      flag_q  <= '0;
      mflag_q <= 1'b0;
    end else begin
      if (we_i) ctl_q <= (ctl_q & ~IRQ_WMASK) | (wdata_i & IRQ_WMASK);
      flag_q  <= flag_d;
      mflag_q <= mflag;
    end
  end

  assign mflag = force_w | (men_w & (|(en_w & flag_q)));
  assign irq_o = mflag & ~mflag_q;

  always_comb begin
    rdata_o = ctl_q;
    rdata_o[FLAG_LSB +: NUM_CH] = flag_q;
    rdata_o[MFLAG_BIT] = mflag;
  end

  // R6: a written 1 clears the flag unless a completion lands with it
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((flag_q & $past(wdata_i[FLAG_LSB +: NUM_CH] & ~done_i)) == '0));
  // R7: a flag rises only for an enabled channel that completed
  p_flag_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((flag_q & ~$past(flag_q) & ~$past(en_w)) == '0));
  p_flag_no_spont_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
  // R9: the interrupt is a single-cycle pulse
  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/dma_reg_front.sv
module dma_reg_front
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [6:0]               addr_i,
  input  logic [31:0]              wdata_i,
  input  logic [NUM_CH-1:0]        done_i,
  output logic [31:0]              rdata_o,
  output logic [NUM_CH*24-1:0]     base_o,
  output logic [NUM_CH*32-1:0]     blk_o,
  output logic [NUM_CH*32-1:0]     ctl_o,
  output logic [NUM_CH-1:0]        chan_en_o,
  output logic [NUM_CH*3-1:0]      chan_prio_o,
  output logic                     irq_o
);
  chan_sel_e         sel;
  logic [NUM_CH-1:0] slot_hit;
  logic [DW-1:0]     chan_rdata [NUM_CH];
  logic [DW-1:0]     prio_q, irq_rdata;
  logic              prio_hit, irq_hit, any_hit;

  always_comb begin
    unique case (addr_i[3:0])
      OFS_BASE: sel = SEL_BASE;
      OFS_BLK:  sel = SEL_BLK;
      OFS_CTL:  sel = SEL_CTL;
      default:  sel = SEL_NONE;
    endcase
  end

  assign prio_hit = (addr_i == ADDR_PRIO);
  assign irq_hit  = (addr_i == ADDR_IRQ);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign slot_hit[c] = (addr_i[6:4] == SLOT_W'(c)) && (sel != SEL_NONE);

    dma_chan_regs i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_i & slot_hit[c]),
      .sel_i   (sel),
      .wdata_i (wdata_i),
      .base_o  (base_o[BASE_W*c +: BASE_W]),
      .blk_o   (blk_o[DW*c +: DW]),
      .ctl_o   (ctl_o[DW*c +: DW]),
      .rdata_o (chan_rdata[c])
    );
  end

  dma_prio_reg #(.NUM_CH(NUM_CH)) i_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i & prio_hit),
    .wdata_i (wdata_i),
    .q_o     (prio_q),
    .en_o    (chan_en_o),
    .prio_o  (chan_prio_o)
  );

  dma_irq_ctrl #(.NUM_CH(NUM_CH)) i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i & irq_hit),
    .wdata_i (wdata_i),
    .done_i  (done_i),
    .rdata_o (irq_rdata),
    .irq_o   (irq_o)
  );

  assign any_hit = (|slot_hit) | prio_hit | irq_hit;

  always_comb begin
    rdata_o = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (slot_hit[c]) rdata_o = chan_rdata[c];
    end
    if (prio_hit) rdata_o = prio_q;
    if (irq_hit)  rdata_o = irq_rdata;
  end

  // R3: no decoded target means all-ones on the read bus
  p_undecoded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_hit |-> (rdata_o == '1));
endmodule

// File: tb/test_dma_reg_front.sv
module test_dma_reg_front;
  localparam int NCH = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [6:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [NCH-1:0]    done = '0;
  logic [31:0]       rdata;
  logic [NCH*24-1:0] base;
  logic [NCH*32-1:0] blk, ctl;
  logic [NCH-1:0]    chan_en;
  logic [NCH*3-1:0]  chan_prio;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_reg_front #(.NUM_CH(NCH)) i_dma_reg_front (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .done_i(done), .rdata_o(rdata), .base_o(base), .blk_o(blk), .ctl_o(ctl),
    .chan_en_o(chan_en), .chan_prio_o(chan_prio), .irq_o(irq)
  );

  // reference model
  logic [23:0]    m_base [NCH];
  logic [31:0]    m_blk  [NCH];
  logic [31:0]    m_ctl  [NCH];
  logic [31:0]    m_prio;
  logic [31:0]    m_ictl;
  logic [NCH-1:0] m_flag;
  bit             m_prev;

  function automatic bit m_mflag();
    return m_ictl[15] | (m_ictl[23] & (|(m_ictl[22:16] & m_flag)));
  endfunction

  function automatic logic [31:0] m_read(logic [6:0] a);
    int s = int'(a[6:4]);
    if (a == 7'h70) return m_prio;
    if (a == 7'h74) return m_ictl | (32'(m_flag) << 24) | (32'(m_mflag()) << 31);
    if (s < NCH) begin
      if (a[3:0] == 4'h0) return {8'h00, m_base[s]};
      if (a[3:0] == 4'h4) return m_blk[s];
      if (a[3:0] == 4'h8) return m_ctl[s];
    end
    return 32'hFFFF_FFFF;
  endfunction

  function automatic string tag_of(logic [6:0] a);
    if (a == 7'h70) return "R4";
    if (a == 7'h74) return "R8";
    if (int'(a[6:4]) < NCH && (a[3:0] == 4'h0 || a[3:0] == 4'h4 || a[3:0] == 4'h8)) return "R2";
    return "R3";
  endfunction

  task automatic m_reset();
    for (int c = 0; c < NCH; c++) begin
      m_base[c] = '0; m_blk[c] = '0; m_ctl[c] = '0;
    end
    m_prio = 32'h0765_4321;
    m_ictl = '0;
    m_flag = '0;
    m_prev = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [NCH-1:0] set_v, clr_v;
      int s;
      m_prev = m_mflag();
      set_v = done & m_ictl[22:16];
      clr_v = '0;
      s = int'(addr[6:4]);
      if (wr) begin
        if (addr == 7'h70) m_prio = wdata;
        else if (addr == 7'h74) begin
          m_ictl = (m_ictl & ~32'h00FF_803F) | (wdata & 32'h00FF_803F);
          clr_v  = wdata[30:24];
        end else if (s < NCH) begin
          if (addr[3:0] == 4'h0) m_base[s] = wdata[23:0];
          if (addr[3:0] == 4'h4) m_blk[s]  = wdata;
          if (addr[3:0] == 4'h8) m_ctl[s]  = wdata;
        end
      end
      m_flag = (m_flag & ~clr_v) | set_v;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tag_of(addr), "rdata", rdata, m_read(addr));
      chk("R9", "irq_o", 32'(irq), 32'(m_mflag() && !m_prev));
      for (int c = 0; c < NCH; c++) begin
        chk("R4", "chan_en", 32'(chan_en[c]), 32'(m_prio[4*c+3]));
        chk("R4", "chan_prio", 32'(chan_prio[3*c +: 3]), 32'(m_prio[4*c +: 3]));
        chk("R10", "base_o", 32'(base[24*c +: 24]), 32'(m_base[c]));
        chk("R10", "blk_o", blk[32*c +: 32], m_blk[c]);
        chk("R10", "ctl_o", ctl[32*c +: 32], m_ctl[c]);
      end
    end
  end

  task automatic wr_done(logic [6:0] a, logic [31:0] d, logic [NCH-1:0] dn, bit do_wr);
    @(posedge clk); #1;
    wr = do_wr; addr = a; wdata = d; done = dn;
    @(posedge clk); #1;
    wr = 0; done = '0;
  endtask

  task automatic wrt(logic [6:0] a, logic [31:0] d);
    wr_done(a, d, '0, 1'b1);
  endtask

  task automatic pulse(logic [NCH-1:0] dn);
    wr_done(7'h7C, 32'h0, dn, 1'b0);
  endtask

  task automatic rd(string tag, logic [6:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, "read", rdata, exp);
  endtask

  task automatic irq_is(string tag, bit exp);
    @(negedge clk);
    chk(tag, "irq pulse", 32'(irq), 32'(exp));
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "irq_o", 32'(irq), 32'h0);
    chk("R1", "chan_en", 32'(chan_en), 32'h0);
    chk("R1", "chan_prio", 32'(chan_prio), 32'(21'o7654321));
    rd("R1", 7'h70, 32'h0765_4321);
    rd("R1", 7'h74, 32'h0);
    rd("R1", 7'h34, 32'h0);
    // R2 slot decode and base width
    wrt(7'h30, 32'hABCD_EF12);
    rd("R2", 7'h30, 32'h00CD_EF12);
    wrt(7'h04, 32'h1234_5678);
    rd("R2", 7'h04, 32'h1234_5678);
    wrt(7'h68, 32'hDEAD_BEEF);
    rd("R2", 7'h68, 32'hDEAD_BEEF);
    rd("R2", 7'h60, 32'h0);
    // R3 holes
    wrt(7'h3C, 32'h5555_5555);
    rd("R3", 7'h3C, 32'hFFFF_FFFF);
    rd("R3", 7'h0C, 32'hFFFF_FFFF);
    wrt(7'h78, 32'h0);
    rd("R3", 7'h78, 32'hFFFF_FFFF);
    rd("R3", 7'h7C, 32'hFFFF_FFFF);
    rd("R3", 7'h30, 32'h00CD_EF12);
    // R4 priority word
    wrt(7'h70, 32'h89AB_CDEF);
    rd("R4", 7'h70, 32'h89AB_CDEF);
    @(negedge clk);
    chk("R4", "chan_en", 32'(chan_en), 32'h7F);
    chk("R4", "chan_prio", 32'(chan_prio), 32'(21'o1234567));
    // R5 / R8 write mask and force
    wrt(7'h74, 32'hFFFF_FFFF);
    irq_is("R9", 1'b1);
    rd("R5", 7'h74, 32'h80FF_803F);
    irq_is("R9", 1'b0);
    wrt(7'h74, 32'h0080_0000);
    rd("R5", 7'h74, 32'h0080_0000);
    // R7 completion with enable clear
    pulse(7'b000_0100);
    rd("R7", 7'h74, 32'h0080_0000);
    // R7 / R8 / R9 completion with enable set
    wrt(7'h74, 32'h0084_0000);
    pulse(7'b000_0100);
    irq_is("R9", 1'b1);
    rd("R8", 7'h74, 32'h8484_0000);
    pulse(7'b000_0100);
    irq_is("R9", 1'b0);
    // R8 bit 31 is not writable
    wrt(7'h74, 32'h8084_0000);
    rd("R8", 7'h74, 32'h8484_0000);
    // R6 write-one-to-clear
    wrt(7'h74, 32'h0484_0000);
    rd("R6", 7'h74, 32'h0084_0000);
    // R7 completion and clear together: set wins
    wr_done(7'h74, 32'h0484_0000, 7'b000_0100, 1'b1);
    rd("R7", 7'h74, 32'h8484_0000);
    // R8 master enable gates, R9 re-arms
    wrt(7'h74, 32'h0004_0000);
    rd("R8", 7'h74, 32'h0404_0000);
    wrt(7'h74, 32'h0084_0000);
    irq_is("R9", 1'b1);
    irq_is("R9", 1'b0);
    // R6 writing zero to a flag keeps it
    rd("R6", 7'h74, 32'h8484_0000);
    repeat (4) @(posedge clk);
    summary();
  end
endmodule